// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

An eight-pin general-purpose I/O port managed through a small register bus. Software programs an output data latch, a per-pin direction mask and a per-pin pull-up mask. It reads back a port status view in which every output pin reports its latched value and every input pin reports its synchronized pad level. Each pin's output enable follows its direction bit. Each pin's pull-up request is formed from the direction bit, the pull-up mask and a 3-bit chip operating mode.

The controller recognises four power conditions. Power-on reset is the asynchronous `rst_n`. Hardware standby, warm (manual) reset and software standby are synchronous level inputs, with that priority. Hardware standby wipes the configuration in the same way as power-on reset. Warm reset and software standby keep it, and they freeze the status view at the value it had just before they began.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After power-on reset, `pin_out`, `pin_oe`, `pin_pu` and `rdata` are all zero, and reads of the latch (address 0), the direction mask (address 1) and the pull-up mask (address 3) return 0x00.
- R2: In normal operation, a write to address 0 sets `pin_out` from the next cycle, and a write to address 1 sets `pin_oe` from the next cycle. A read strobe sampled on one clock edge places the addressed register on `rdata` after that edge, and `rdata` holds until the next read.
- R3: A read of address 2 returns, for each bit, the latch bit where the direction bit is 1 and the synchronized pin level where it is 0.
- R4: A write to address 2 changes neither the latch, the direction mask, the pull-up mask nor any output pin.
- R5: `pin_pu[i]` is 1 exactly when direction bit i is 0, pull-up bit i is 1, and `op_mode` is 6 or 7.
- R6: While `hw_stby` is 1, the latch, the direction mask, the pull-up mask and `rdata` are cleared and writes are ignored. After it is released, a status read returns the raw pin levels.
- R7: While `warm_rst` is 1, the latch, the direction mask and the pull-up mask keep their values, writes are ignored, and a status read returns the status held from before the reset.
- R8: While `sw_stby` is 1, writes are ignored, the configuration is kept, and a status read returns the value captured on entry, whatever the pins do. After release the status follows the pins again.
- R9: A pin change made between two clock edges is not returned by a status read whose strobe is sampled on the third edge after the change. It is returned by one sampled on the fourth edge: two synchronizer stages, one status stage and one read stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hw_stby | input | 1 | Hardware standby, clears configuration |
| warm_rst | input | 1 | Warm reset, configuration retained |
| sw_stby | input | 1 | Software standby, configuration retained |
| op_mode | input | 3 | Chip operating mode, gates pull-ups |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |

## Verification
The hardest situation to reach is the frozen status view: the status must still show the pins from before a warm reset or software standby even though the pads have moved since. The stimulus settles a known pin pattern and enters the condition. It then drives a different pattern and attempts register writes before reading status and the other registers. After release it checks that the new pins appear. The exact four-edge pin-to-read latency is probed by holding the read strobe high across a pin change and comparing every cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;
  localparam int MODE_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_LATCH = 2'd0,
    REG_DIR   = 2'd1,
    REG_STAT  = 2'd2,
    REG_PULL  = 2'd3
  } gpio_reg_e;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_SOFT = 2'd1,
    PS_WARM = 2'd2,
    PS_HARD = 2'd3
  } gpio_pstate_e;

  localparam logic [MODE_W-1:0] PU_MODE_LO = 3'd6;
  localparam logic [MODE_W-1:0] PU_MODE_HI = 3'd7;

  function automatic gpio_pstate_e pstate_decode(input logic hw, input logic warm, input logic sw);
    gpio_pstate_e ps;
    if (hw)        ps = PS_HARD;
    else if (warm) ps = PS_WARM;
    else if (sw)   ps = PS_SOFT;
    else           ps = PS_RUN;
    return ps;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stg_d[s] = d_async;
      end else begin : g_next
        always_comb stg_d[s] = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d[s];
      end
    end
  endgenerate

  assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gpio_pstate_e      pstate,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pull_q
);
  logic [W-1:0] latch_d, dir_d, pull_d;
  logic         wr_ok;

  always_comb begin
    wr_ok   = wr_en && (pstate == PS_RUN);
    latch_d = latch_q;
    dir_d   = dir_q;
    pull_d  = pull_q;
    if (pstate == PS_HARD) begin
      latch_d = '0;
      dir_d   = '0;
      pull_d  = '0;
    end else if (wr_ok) begin
      case (gpio_reg_e'(addr))
        REG_LATCH: latch_d = wdata;
        REG_DIR:   dir_d   = wdata;
        REG_PULL:  pull_d  = wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
      pull_q  <= pull_d;
    end
  end
endmodule

// File: rtl/gpio_pullup.sv
module gpio_pullup
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [MODE_W-1:0] op_mode,
  input  logic [W-1:0]      dir_q,
  input  logic [W-1:0]      pull_q,
  output logic [W-1:0]      pu_en
);
  logic mode_ok;
  always_comb mode_ok = (op_mode == PU_MODE_LO) || (op_mode == PU_MODE_HI);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign pu_en[i] = mode_ok & pull_q[i] & ~dir_q[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_readpath.sv
module gpio_readpath
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gpio_pstate_e      pstate,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      latch_q,
  input  logic [W-1:0]      dir_q,
  input  logic [W-1:0]      pull_q,
  input  logic [W-1:0]      pin_sync,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] stat_mux, stat_q, stat_d;
  logic [W-1:0] rdata_d;
  logic         stat_en;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_mux
      assign stat_mux[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
    end
  endgenerate

  always_comb begin
    stat_en = (pstate == PS_RUN) || (pstate == PS_HARD);
    stat_d  = stat_en ? stat_mux : stat_q;
  end

  always_comb begin
    rdata_d = rdata;
    if (pstate == PS_HARD) begin
      rdata_d = '0;
    end else if (rd_en) begin
      case (gpio_reg_e'(addr))
        REG_LATCH: rdata_d = latch_q;
        REG_DIR:   rdata_d = dir_q;
        REG_STAT:  rdata_d = stat_q;
        REG_PULL:  rdata_d = pull_q;
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      rdata  <= '0;
    end else begin
      stat_q <= stat_d;
      rdata  <= rdata_d;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              warm_rst,
  input  logic              sw_stby,
  input  logic [MODE_W-1:0] op_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pin_pu
);
  localparam int SYNC_STAGES = 2;

  gpio_pstate_e pstate;
  logic [W-1:0] latch_q, dir_q, pull_q, pin_sync;

  always_comb pstate = pstate_decode(hw_stby, warm_rst, sw_stby);

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .pstate(pstate), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q)
  );

  gpio_pullup #(.W(W)) u_pull (
    .op_mode(op_mode), .dir_q(dir_q), .pull_q(pull_q), .pu_en(pin_pu)
  );

  gpio_readpath #(.W(W)) u_read (
    .clk(clk), .rst_n(rst_n), .pstate(pstate), .rd_en(rd_en), .addr(addr),
    .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q), .pin_sync(pin_sync),
    .rdata(rdata)
  );

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_stby,
  input logic              warm_rst,
  input logic              sw_stby,
  input logic [MODE_W-1:0] op_mode,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [W-1:0]      wdata,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      pin_oe,
  input logic [W-1:0]      pin_pu
);
  assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_LATCH && !hw_stby && !warm_rst && !sw_stby) |=> (pin_out == $past(wdata)));

  assert_pu_not_on_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_pu & pin_oe) == '0));

  assert_pu_mode_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu != '0) |-> (op_mode == PU_MODE_LO || op_mode == PU_MODE_HI));

  assert_hard_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (pin_out == '0 && pin_oe == '0 && pin_pu == '0));

  assert_warm_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst && !hw_stby) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_soft_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !warm_rst && !hw_stby) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .warm_rst(warm_rst),
  .sw_stby(sw_stby), .op_mode(op_mode), .addr(addr), .wr_en(wr_en),
  .wdata(wdata), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, hw_stby, warm_rst, sw_stby, wr_en, rd_en;
  logic [2:0] op_mode;
  logic [1:0] addr;
  logic [W-1:0] wdata, rdata, pin_in, pin_out, pin_oe, pin_pu;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .warm_rst(warm_rst),
    .sw_stby(sw_stby), .op_mode(op_mode), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, d, l, p, exp;
    rst_n = 0; hw_stby = 0; warm_rst = 0; sw_stby = 0; op_mode = 3'd7;
    addr = 0; wr_en = 0; rd_en = 0; wdata = 0; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 pin_out", pin_out, 8'h00);
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 pin_pu", pin_pu, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    rd(2'd0, v); check("R1 latch", v, 8'h00);
    rd(2'd1, v); check("R1 dir", v, 8'h00);
    rd(2'd3, v); check("R1 pull", v, 8'h00);

    // R2 write/readback
    wr(2'd0, 8'h5A); check("R2 pin_out", pin_out, 8'h5A);
    wr(2'd1, 8'hC3); check("R2 pin_oe", pin_oe, 8'hC3);
    wr(2'd3, 8'h96);
    rd(2'd0, v); check("R2 latch read", v, 8'h5A);
    rd(2'd1, v); check("R2 dir read", v, 8'hC3);
    rd(2'd3, v); check("R2 pull read", v, 8'h96);
    repeat (2) @(negedge clk);
    check("R2 rdata holds", rdata, 8'h96);

    // R4 write to status address ignored
    wr(2'd2, 8'hFF);
    check("R4 pin_out", pin_out, 8'h5A);
    check("R4 pin_oe", pin_oe, 8'hC3);
    rd(2'd0, v); check("R4 latch", v, 8'h5A);
    rd(2'd1, v); check("R4 dir", v, 8'hC3);
    rd(2'd3, v); check("R4 pull", v, 8'h96);

    // R3 status mux sweep over every direction mask
    for (int i = 0; i < 256; i++) begin
      d = 8'(i); l = 8'(i * 37 + 11); p = 8'(i ^ 8'h3C);
      wr(2'd1, d); wr(2'd0, l);
      pin_in = p;
      settle();
      rd(2'd2, v);
      exp = (d & l) | (~d & p);
      check("R3 status mux", v, exp);
    end

    // R5 pull-up gating sweep
    for (int m = 0; m < 8; m++) begin
      op_mode = 3'(m);
      for (int k = 0; k < 4; k++) begin
        d = (k == 0) ? 8'h00 : (k == 1) ? 8'h0F : (k == 2) ? 8'h55 : 8'hFF;
        wr(2'd1, d);
        for (int j = 0; j < 256; j += 7) begin
          wr(2'd3, 8'(j));
          exp = (m >= 6) ? (8'(j) & ~d) : 8'h00;
          check("R5 pin_pu", pin_pu, exp);
        end
      end
    end
    op_mode = 3'd7;

    // R9 synchronizer latency
    wr(2'd1, 8'h00);
    pin_in = 8'h11; settle(); settle();
    @(negedge clk);
    pin_in = 8'hEE; addr = 2'd2; rd_en = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R9 third edge old", rdata, 8'h11);
    @(negedge clk);
    check("R9 fourth edge new", rdata, 8'hEE);
    rd_en = 1'b0;

    // R7 warm reset retention
    wr(2'd1, 8'hF0); wr(2'd0, 8'hA5); wr(2'd3, 8'h0C);
    pin_in = 8'h3C; settle();
    @(negedge clk); warm_rst = 1'b1;
    pin_in = 8'hC3;
    wr(2'd0, 8'h00); wr(2'd1, 8'h0F);
    settle();
    rd(2'd2, v); check("R7 status held", v, 8'hAC);
    check("R7 pin_out kept", pin_out, 8'hA5);
    check("R7 pin_oe kept", pin_oe, 8'hF0);
    rd(2'd3, v); check("R7 pull kept", v, 8'h0C);
    @(negedge clk); warm_rst = 1'b0;
    settle();
    rd(2'd2, v); check("R7 status after release", v, 8'hA3);

    // R8 software standby
    pin_in = 8'h5A; settle();
    @(negedge clk); sw_stby = 1'b1;
    pin_in = 8'hA5;
    wr(2'd0, 8'h11); wr(2'd3, 8'hFF);
    settle();
    rd(2'd2, v); check("R8 status frozen", v, 8'hAA);
    check("R8 pin_out kept", pin_out, 8'hA5);
    rd(2'd3, v); check("R8 pull kept", v, 8'h0C);
    @(negedge clk); sw_stby = 1'b0;
    settle();
    rd(2'd2, v); check("R8 status follows", v, 8'hA5);

    // R6 hardware standby
    @(negedge clk); hw_stby = 1'b1;
    wr(2'd0, 8'h77);
    check("R6 rdata cleared", rdata, 8'h00);
    @(negedge clk); hw_stby = 1'b0;
    check("R6 pin_out", pin_out, 8'h00);
    check("R6 pin_oe", pin_oe, 8'h00);
    rd(2'd3, v); check("R6 pull", v, 8'h00);
    pin_in = 8'h69; settle();
    rd(2'd2, v); check("R6 status raw pins", v, 8'h69);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule